// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block holds the flow-control and protected-register logic for one UART channel whose receive and transmit FIFOs are 64 bytes deep. A CPU writes eight byte-wide registers over a simple write strobe. From those registers, the receive FIFO fill level, the received-character stream and the CTS input, the block drives the RTS line and a transmit-hold signal. It also raises a special-character flag and withholds writes to protected register fields.

RTS flow control uses two programmable thresholds, which gives hysteresis. Each threshold is a 4-bit code, and the code times four is the FIFO level it stands for. RTS rises at the halt threshold, falls at the resume threshold, and keeps its value in the band between them. A feature control register holds four things: the CTS and RTS enables, the special-character enable, and a write-enable bit that guards the upper fields of the interrupt-enable, FIFO-control and modem-control registers. The 16-bit baud divisor latches are locked while the sleep bit of the interrupt-enable register is set. The serial shifters consume the outputs. The transmit-hold signal only keeps the next character from starting, so a character already on the line completes.

Top module: `uart_flowctl`

## Requirements
- R1: While feature bit 7 (CTS enable) is 1, `tx_hold` follows `cts` in the same cycle. While that bit is 0, `tx_hold` is 0 whatever `cts` does.
- R2: While feature bit 6 (RTS enable) is 1, the behaviour at each clock edge is as follows. If `rx_level` >= 4*TCR[3:0], `rts` becomes 1. Otherwise, if `rx_level` <= 4*TCR[7:4], `rts` becomes 0. Otherwise `rts` keeps its value. The halt test has priority.
- R3: When feature bit 5 is 1, a byte is a hit if `rx_valid` is 1, `rx_frame_err` is 0 and `rx_data` equals the compare register on all 8 bits. A hit sets `spchar_flag` to 1 at the next edge. No other received byte sets the flag.
- R4: Register addresses are IER=0, FCR=1, MCR=2, feature register=3, TCR=4, compare register=5, divisor low=6 and divisor high=7. While feature bit 4 is 0, a write leaves IER[7:4], FCR[5:4] and MCR[7:5] unchanged and updates the other bits. While feature bit 4 is 1, a write updates all bits.
- R5: `swfc_mode` presents feature bits 3:0 as last written.
- R6: A write to address 6 or 7 updates `divisor[7:0]` or `divisor[15:8]` only while IER[4] is 0. While IER[4] is 1, the divisor is unchanged.
- R7: After reset, every register is 0, so `rts`, `tx_hold`, `spchar_flag`, `swfc_mode`, `ier_q`, `fcr_q`, `mcr_q` and `divisor` are all 0.
- R8: A pulse on `iir_rd` clears `spchar_flag` at the next edge. If a hit occurs in the same cycle, the set wins.
- R9: While feature bit 6 is 0, `rts` is 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| iir_rd | input | 1 | Interrupt identification read pulse |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_frame_err | input | 1 | Framing error on the received byte |
| cts | input | 1 | Clear-to-send input, HIGH means stop |
| rts | output | 1 | Request-to-send output, HIGH means halt |
| tx_hold | output | 1 | Blocks the start of the next transmit character |
| spchar_flag | output | 1 | Special character detected (IIR bit 4) |
| swfc_mode | output | 4 | Software flow control mode code |
| ier_q | output | 8 | Interrupt enable register |
| fcr_q | output | 8 | FIFO control register |
| mcr_q | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor |

## Verification
The hardest case to reach is RTS inside its hysteresis band. The bench has to program both thresholds, climb the FIFO level past the halt point and then descend into the band, so that it can show RTS holding its value instead of following the level. The stimulus drives the level as a bounded random walk with small steps, and rewrites TCR from time to time. The two other collisions are an interrupt-identification read arriving in the same cycle as a matching byte, and a divisor write arriving while sleep is set. To make both common, received bytes are biased toward the current compare value, and the sleep bit is toggled while writes to addresses 6 and 7 are frequent.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_IER  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FCR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MCR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FEAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TCR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd5;
  localparam logic [ADDR_W-1:0] A_DLO  = 3'd6;
  localparam logic [ADDR_W-1:0] A_DHI  = 3'd7;
  localparam int F_CTS  = 7;
  localparam int F_RTS  = 6;
  localparam int F_SPC  = 5;
  localparam int F_WEN  = 4;
  localparam int IER_SLEEP = 4;
endpackage

// File: rtl/uart_fc_regs.sv
module uart_fc_regs
  import uart_fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        ier,
  output logic [7:0]        fcr,
  output logic [7:0]        mcr,
  output logic [7:0]        feat,
  output logic [7:0]        tcr,
  output logic [7:0]        cmp,
  output logic [15:0]       div
);
  localparam logic [7:0] IER_PROT = 8'hF0;
  localparam logic [7:0] FCR_PROT = 8'h30;
  localparam logic [7:0] MCR_PROT = 8'hE0;

  logic [7:0]  ier_d, fcr_d, mcr_d, feat_d, tcr_d, cmp_d;
  logic [15:0] div_d;
  logic        wen, sleep;

  assign wen   = feat[F_WEN];
  assign sleep = ier[IER_SLEEP];

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] nw,
                                       input logic [7:0] prot, input logic open);
    merge = open ? nw : ((old & prot) | (nw & ~prot));
  endfunction

  always_comb begin
    ier_d  = ier;
    fcr_d  = fcr;
    mcr_d  = mcr;
    feat_d = feat;
    tcr_d  = tcr;
    cmp_d  = cmp;
    div_d  = div;
    if (wr) begin
      unique case (addr)
        A_IER:  ier_d  = merge(ier, wdata, IER_PROT, wen);
        A_FCR:  fcr_d  = merge(fcr, wdata, FCR_PROT, wen);
        A_MCR:  mcr_d  = merge(mcr, wdata, MCR_PROT, wen);
        A_FEAT: feat_d = wdata;
        A_TCR:  tcr_d  = wdata;
        A_CMP:  cmp_d  = wdata;
        A_DLO:  if (!sleep) div_d[7:0]  = wdata;
        A_DHI:  if (!sleep) div_d[15:8] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier  <= '0;
      fcr  <= '0;
      mcr  <= '0;
      feat <= '0;
      tcr  <= '0;
      cmp  <= '0;
      div  <= '0;
    end else if (wr) begin
      ier  <= ier_d;
      fcr  <= fcr_d;
      mcr  <= mcr_d;
      feat <= feat_d;
      tcr  <= tcr_d;
      cmp  <= cmp_d;
      div  <= div_d;
    end
  end
endmodule

// File: rtl/uart_fc_rts.sv
module uart_fc_rts #(
  parameter int LVL_W    = 7,
  parameter int SCALE_SH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [7:0]       tcr,
  input  logic [LVL_W-1:0] level,
  output logic             rts
);
  logic [LVL_W-1:0] halt_lvl, resume_lvl;
  logic             rts_d;

  assign halt_lvl   = LVL_W'(tcr[3:0]) << SCALE_SH;
  assign resume_lvl = LVL_W'(tcr[7:4]) << SCALE_SH;

  always_comb begin
    rts_d = rts;
    if (!en)                       rts_d = 1'b0;
    else if (level >= halt_lvl)    rts_d = 1'b1;
    else if (level <= resume_lvl)  rts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts <= 1'b0;
    else        rts <= rts_d;
  end
endmodule

// File: rtl/uart_fc_spchar.sv
module uart_fc_spchar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] cmp,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_frame_err,
  input  logic       iir_rd,
  output logic       hit,
  output logic       flag
);
  logic flag_d, flag_ce;

  assign hit     = en && rx_valid && !rx_frame_err && (rx_data == cmp);
  assign flag_ce = hit || iir_rd;
  assign flag_d  = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_ce) flag <= flag_d;
  end
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
  import uart_fc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int SCALE_SH   = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              iir_rd,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_frame_err,
  input  logic              cts,
  output logic              rts,
  output logic              tx_hold,
  output logic              spchar_flag,
  output logic [3:0]        swfc_mode,
  output logic [7:0]        ier_q,
  output logic [7:0]        fcr_q,
  output logic [7:0]        mcr_q,
  output logic [15:0]       divisor
);
  logic [7:0] feat, tcr, cmp;
  logic       spc_hit;

  uart_fc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ier(ier_q), .fcr(fcr_q), .mcr(mcr_q), .feat(feat), .tcr(tcr), .cmp(cmp),
    .div(divisor)
  );

  uart_fc_rts #(.LVL_W(LVL_W), .SCALE_SH(SCALE_SH)) u_rts (
    .clk(clk), .rst_n(rst_n), .en(feat[F_RTS]), .tcr(tcr), .level(rx_level),
    .rts(rts)
  );

  uart_fc_spchar u_spc (
    .clk(clk), .rst_n(rst_n), .en(feat[F_SPC]), .cmp(cmp), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .iir_rd(iir_rd),
    .hit(spc_hit), .flag(spchar_flag)
  );

  assign tx_hold   = feat[F_CTS] & cts;
  assign swfc_mode = feat[3:0];
endmodule

// File: rtl/uart_flowctl_chk.sv
module uart_flowctl_chk #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       feat,
  input logic [7:0]       tcr,
  input logic [LVL_W-1:0] rx_level,
  input logic             cts,
  input logic             rts,
  input logic             tx_hold,
  input logic             spc_hit,
  input logic             iir_rd,
  input logic             spchar_flag,
  input logic [7:0]       ier_q,
  input logic [15:0]      divisor
);
  // R1
  cts_low_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cts |-> !tx_hold);
  // R2
  rts_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (feat[6] && rx_level >= (LVL_W'(tcr[3:0]) << 2)) |=> rts);
  // R9
  rts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feat[6] |=> !rts);
  // R6
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_q[4] |=> $stable(divisor));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !spc_hit) |=> !spchar_flag);
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spc_hit |=> spchar_flag);
endmodule

bind uart_flowctl uart_flowctl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .feat(feat), .tcr(tcr), .rx_level(rx_level),
  .cts(cts), .rts(rts), .tx_hold(tx_hold), .spc_hit(spc_hit), .iir_rd(iir_rd),
  .spchar_flag(spchar_flag), .ier_q(ier_q), .divisor(divisor)
);

// File: tb/tb_uart_flowctl.sv
module tb_uart_flowctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        iir_rd = 1'b0;
  logic [6:0]  rx_level = '0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_frame_err = 1'b0;
  logic        cts = 1'b0;
  logic        rts, tx_hold, spchar_flag;
  logic [3:0]  swfc_mode;
  logic [7:0]  ier_q, fcr_q, mcr_q;
  logic [15:0] divisor;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_ier, m_fcr, m_mcr, m_feat, m_tcr, m_cmp, m_div, m_rts, m_flag;

  always #2 clk = ~clk;

  uart_flowctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .iir_rd(iir_rd), .rx_level(rx_level),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .cts(cts), .rts(rts), .tx_hold(tx_hold), .spchar_flag(spchar_flag),
    .swfc_mode(swfc_mode), .ier_q(ier_q), .fcr_q(fcr_q), .mcr_q(mcr_q),
    .divisor(divisor)
  );

  function automatic int upd(int old, int nw, int prot, int open);
    return open != 0 ? nw : ((old & prot) | (nw & ~prot & 255));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier <= 0; m_fcr <= 0; m_mcr <= 0; m_feat <= 0; m_tcr <= 0;
      m_cmp <= 0; m_div <= 0; m_rts <= 0; m_flag <= 0;
    end else begin
      int wen, halt, res, lvl;
      wen  = (m_feat >> 4) & 1;
      halt = (m_tcr & 15) * 4;
      res  = ((m_tcr >> 4) & 15) * 4;
      lvl  = int'(rx_level);
      if (((m_feat >> 6) & 1) == 0) m_rts <= 0;
      else if (lvl >= halt)         m_rts <= 1;
      else if (lvl <= res)          m_rts <= 0;
      if (((m_feat >> 5) & 1) == 1 && rx_valid && !rx_frame_err && int'(rx_data) == m_cmp)
        m_flag <= 1;
      else if (iir_rd)
        m_flag <= 0;
      if (bus_wr) begin
        case (int'(bus_addr))
          0: m_ier  <= upd(m_ier, int'(bus_wdata), 'hF0, wen);
          1: m_fcr  <= upd(m_fcr, int'(bus_wdata), 'h30, wen);
          2: m_mcr  <= upd(m_mcr, int'(bus_wdata), 'hE0, wen);
          3: m_feat <= int'(bus_wdata);
          4: m_tcr  <= int'(bus_wdata);
          5: m_cmp  <= int'(bus_wdata);
          6: if (((m_ier >> 4) & 1) == 0) m_div <= (m_div & 'hFF00) | int'(bus_wdata);
          7: if (((m_ier >> 4) & 1) == 0) m_div <= (m_div & 'h00FF) | (int'(bus_wdata) << 8);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    vectors++;
    chk("R1 tx_hold", int'(tx_hold), ((m_feat >> 7) & 1) & int'(cts));
    chk("R2/R9 rts", int'(rts), m_rts);
    chk("R3/R8 spchar_flag", int'(spchar_flag), m_flag);
    chk("R5 swfc_mode", int'(swfc_mode), m_feat & 15);
    chk("R4 ier", int'(ier_q), m_ier);
    chk("R4 fcr", int'(fcr_q), m_fcr);
    chk("R4 mcr", int'(mcr_q), m_mcr);
    chk("R6 divisor", int'(divisor), m_div);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    step();
    bus_wr = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lvl;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 rts", int'(rts), 0);
    chk("R7 flag", int'(spchar_flag), 0);
    chk("R7 divisor", int'(divisor), 0);
    chk("R7 ier", int'(ier_q), 0);
    rst_n = 1;
    step();
    // R4 protected fields closed
    wr(0, 'hFF); chk("R4 ier closed", int'(ier_q), 'h0F);
    wr(2, 'hFF); chk("R4 mcr closed", int'(mcr_q), 'h1F);
    // R6 divisor while awake
    wr(6, 'h34); wr(7, 'h12); chk("R6 divisor open", int'(divisor), 'h1234);
    // R5 and open write enable
    wr(3, 'hFA); chk("R5 mode", int'(swfc_mode), 'hA);
    wr(0, 'h1F); chk("R4 ier open", int'(ier_q), 'h1F);
    // R6 lock under sleep
    wr(6, 'hAA); chk("R6 divisor locked", int'(divisor), 'h1234);
    wr(0, 'h00);
    // R1 CTS hold
    cts = 1; #0; @(negedge clk); chk("R1 hold on", int'(tx_hold), 1); compare_all();
    cts = 0;
    // R2 hysteresis: halt 40, resume 16
    wr(4, 'h4A);
    rx_level = 40; step(); step(); chk("R2 halt", int'(rts), 1);
    rx_level = 30; step(); step(); chk("R2 band hold", int'(rts), 1);
    rx_level = 16; step(); step(); chk("R2 resume", int'(rts), 0);
    rx_level = 30; step(); step(); chk("R2 band low", int'(rts), 0);
    // R3 framing-error byte ignored, then match and R8 collision
    wr(5, 'h13);
    rx_valid = 1; rx_data = 'h13; rx_frame_err = 1; step();
    rx_frame_err = 0; rx_valid = 0; step(); chk("R3 ferr ignored", int'(spchar_flag), 0);
    rx_valid = 1; iir_rd = 1; step(); chk("R8 set wins", int'(spchar_flag), 1);
    rx_valid = 0; step(); chk("R8 cleared", int'(spchar_flag), 0);
    iir_rd = 0;
    // R9 disable RTS
    rx_level = 64; step(); wr(3, 'h20); step(); chk("R9 rts off", int'(rts), 0);
    // random phase
    lvl = 32;
    for (int i = 0; i < 20000; i++) begin
      lvl = lvl + int'($urandom_range(6)) - 3;
      if (lvl < 0) lvl = 0;
      if (lvl > 64) lvl = 64;
      rx_level     = 7'(lvl);
      bus_wr       = ($urandom_range(9) < 3);
      bus_addr     = 3'($urandom_range(7));
      bus_wdata    = 8'($urandom);
      cts          = 1'($urandom);
      iir_rd       = ($urandom_range(7) == 0);
      rx_valid     = 1'($urandom);
      rx_frame_err = ($urandom_range(5) == 0);
      rx_data      = ($urandom_range(1) == 0) ? 8'(m_cmp) : 8'($urandom);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule